// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block pulls outgoing frames out of system memory by walking a chain of four-word buffer descriptors. Software places a frame in a buffer and fills in a descriptor. Word 0 holds the buffer address with an ownership flag in its top bit, the word at byte offset 8 holds the frame length, and the word at offset 12 links to the next descriptor. Software then loads the descriptor pointer register and writes the transmit control register with its go bit set.

For each start the engine makes one pass over the current descriptor. It reads word 0 and gives up if software does not own the buffer to the engine. It then reads the length and drops frames longer than its buffer capacity without touching the descriptor. Otherwise it fetches the bytes one at a time over a simple memory master port and streams them out on a valid/ready byte interface, marking the final byte. After the last byte it writes a completion status word, hands the descriptor back to software by clearing the ownership flag, and loads the link word as the new current pointer. If enabled, it then pulses an interrupt.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the descriptor pointer register (register address 1) reads 0xFFFFFFFF, the control register (address 0) reads 0, and irq, tx_valid and mem_req are low.
- R2: A write to the control register stores the written value, which reads back unchanged. When bit 0 (go) of the value is set and the engine is idle, the write starts exactly one descriptor pass at the current pointer.
- R3: When bit 31 of descriptor word 0 is clear, the pass ends without sending any byte and without any memory write. The pointer register keeps its value.
- R4: The frame length is bits 15:0 of the word at descriptor offset 8, and bits 31:16 of that word are ignored. A length above BUF_BYTES sends nothing, makes no memory write and leaves the pointer unchanged. A length equal to BUF_BYTES is sent.
- R5: Frame bytes are read from the buffer address (word 0 with bit 31 cleared) plus 0, 1, 2 and so on, in increasing order. Each byte goes out on tx_data with tx_valid and moves on only when tx_ready is high. tx_data stays stable while tx_ready is low.
- R6: tx_last is high with the final byte of a frame and low with every other byte.
- R7: After the last byte, the word at descriptor offset 8 is written with the value (1 << 16) | length.
- R8: After the status write, descriptor word 0 is written with the buffer address and bit 31 clear. No other memory write happens in a pass.
- R9: At the end of a pass, the pointer register is loaded with the word read from descriptor offset 12.
- R10: irq is a one-cycle pulse at the end of a completed pass, raised only when bit 2 of the control register is set.
- R11: Register address 2 bit 0 reads 1 while a pass is in progress. While a pass is in progress, a go write starts no further pass and a write to the pointer register is ignored.
- R12: A zero-length frame sends no bytes but still gets its status write, ownership release and link load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 descriptor pointer, 2 busy |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = word write, 0 = read |
| mem_byte | output | 1 | 1 = byte read (data in mem_rdata[7:0]) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Downstream accepts byte |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The hardest case to reach is a start or pointer write that arrives in the middle of a pass. A frame normally finishes within a few dozen cycles, so the bench holds the engine busy on purpose. It pairs a frame at exactly the buffer capacity with a downstream that accepts only one cycle in five. That opens a long window in which the busy bit, the rejected go write and the rejected pointer write can all be observed. The oversized-length case is made harder by filling the upper half of the length word with non-zero data, so that only correct masking decides whether the frame is sent.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_OWN, S_LEN, S_BYTE, S_SEND, S_STAT, S_REL, S_LINK
  } walk_state_t;

  localparam int OWN_BIT      = 31;
  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_IRQ_BIT = 2;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_PTR  = 2'd1;
  localparam logic [1:0] REG_BUSY = 2'd2;
  localparam logic [31:0] OFS_LEN  = 32'd8;
  localparam logic [31:0] OFS_LINK = 32'd12;
  localparam logic [15:0] DONE_CODE = 16'h0001;

  // status word written back after a frame has gone out
  function automatic logic [31:0] status_word(input logic [15:0] len);
    return {DONE_CODE, len};
  endfunction

  // true when a frame of this length can be carried
  function automatic logic frame_fits(input logic [15:0] len, input int cap);
    return 32'(len) <= 32'(cap);
  endfunction

  // byte address of frame byte idx inside a buffer
  function automatic logic [31:0] byte_addr(input logic [31:0] bufw, input logic [15:0] idx);
    return {1'b0, bufw[30:0]} + 32'(idx);
  endfunction

  // word 0 handed back to software
  function automatic logic [31:0] release_word(input logic [31:0] bufw);
    return {1'b0, bufw[30:0]};
  endfunction

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          ptr_load,
  input  logic [DW-1:0] ptr_next,
  output logic          start,
  output logic [DW-1:0] cur_ptr,
  output logic          irq_en
);

  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] ptr_q;
  logic          wr_ctrl, wr_ptr;

  assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
  assign wr_ptr  = reg_wr && (reg_addr == REG_PTR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ptr_q  <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (ptr_load)             ptr_q <= ptr_next;
      else if (wr_ptr && !busy) ptr_q <= reg_wdata;
    end
  end

  assign start   = wr_ctrl && reg_wdata[CTRL_GO_BIT] && !busy;
  assign cur_ptr = ptr_q;
  assign irq_en  = ctrl_q[CTRL_IRQ_BIT];

  always_comb begin
    case (reg_addr)
      REG_CTRL: reg_rdata = ctrl_q;
      REG_PTR:  reg_rdata = ptr_q;
      REG_BUSY: reg_rdata = {{(DW-1){1'b0}}, busy};
      default:  reg_rdata = '0;
    endcase
  end

  // R11: a pass in progress freezes the pointer unless the engine itself loads it
  p_ptr_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ptr_load |=> ptr_q == $past(ptr_q));

  // R2: a start is only ever taken while the engine is idle
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/txdma_walker.sv
module txdma_walker
  import txdma_pkg::*;
#(
  parameter int BUF_BYTES = 1536,
  parameter int DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] cur_ptr,
  input  logic          irq_en,
  output logic          busy,
  output logic          ptr_load,
  output logic [DW-1:0] ptr_next,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          irq
);

  walk_state_t   state;
  logic [DW-1:0] desc_q;
  logic [DW-1:0] buf_q;
  logic [15:0]   len_q;
  logic [15:0]   idx_q;
  logic [7:0]    byte_q;
  logic          irq_q;
  logic          last_byte;
  logic          tx_fire;
  logic [15:0]   len_rd;

  assign len_rd    = mem_rdata[15:0];
  assign last_byte = (idx_q == len_q - 16'd1);
  assign tx_fire   = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      desc_q <= '0;
      buf_q  <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      byte_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= ptr_load && irq_en;
      case (state)
        S_IDLE: if (start) begin
          desc_q <= cur_ptr;
          state  <= S_OWN;
        end
        S_OWN: if (mem_ack) begin
          buf_q <= mem_rdata;
          state <= mem_rdata[OWN_BIT] ? S_LEN : S_IDLE;
        end
        S_LEN: if (mem_ack) begin
          len_q <= len_rd;
          idx_q <= '0;
          if (!frame_fits(len_rd, BUF_BYTES)) state <= S_IDLE;
          else if (len_rd == 16'd0)           state <= S_STAT;
          else                                state <= S_BYTE;
        end
        S_BYTE: if (mem_ack) begin
          byte_q <= mem_rdata[7:0];
          state  <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          idx_q <= idx_q + 16'd1;
          state <= last_byte ? S_STAT : S_BYTE;
        end
        S_STAT: if (mem_ack) state <= S_REL;
        S_REL:  if (mem_ack) state <= S_LINK;
        S_LINK: if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_byte  = 1'b0;
    mem_addr  = desc_q;
    mem_wdata = '0;
    case (state)
      S_OWN:  mem_addr = desc_q;
      S_LEN:  mem_addr = desc_q + OFS_LEN;
      S_BYTE: begin
        mem_byte = 1'b1;
        mem_addr = byte_addr(buf_q, idx_q);
      end
      S_STAT: begin
        mem_we    = 1'b1;
        mem_addr  = desc_q + OFS_LEN;
        mem_wdata = status_word(len_q);
      end
      S_REL: begin
        mem_we    = 1'b1;
        mem_addr  = desc_q;
        mem_wdata = release_word(buf_q);
      end
      S_LINK: mem_addr = desc_q + OFS_LINK;
      default: mem_req = 1'b0;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign ptr_load = (state == S_LINK) && mem_ack;
  assign ptr_next = mem_rdata;
  assign tx_valid = (state == S_SEND);
  assign tx_data  = byte_q;
  assign tx_last  = tx_valid && last_byte;
  assign irq      = irq_q;

  // R5: a memory request holds its address and kind until acknowledged
  p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R5: an offered byte waits unchanged for the consumer
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R10: interrupt lasts one cycle
  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R10: interrupt only follows a link load with the enable set
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ptr_load) && $past(irq_en));

  // R3: memory is written only for a descriptor found owned
  p_write_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> buf_q[OWN_BIT]);

  // R4: no byte leaves for a frame above capacity
  p_len_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |-> frame_fits(len_q, BUF_BYTES));

  // R9: link load closes the pass
  p_link_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> !busy);

endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txdma_pkg::*;
#(
  parameter int BUF_BYTES = 1536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_byte,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);

  localparam int DW = 32;

  logic          busy, ptr_load, start, irq_en;
  logic [DW-1:0] ptr_next, cur_ptr;

  txdma_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .ptr_load  (ptr_load),
    .ptr_next  (ptr_next),
    .start     (start),
    .cur_ptr   (cur_ptr),
    .irq_en    (irq_en)
  );

  txdma_walker #(.BUF_BYTES(BUF_BYTES), .DW(DW)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cur_ptr   (cur_ptr),
    .irq_en    (irq_en),
    .busy      (busy),
    .ptr_load  (ptr_load),
    .ptr_next  (ptr_next),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_byte  (mem_byte),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .irq       (irq)
  );

  // R1: nothing is requested or offered while reset is applied
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !mem_req && !tx_valid && !irq);

endmodule

// File: tb/txdesc_dma_bench.sv
module txdesc_dma_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CAP        = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_byte;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        irq;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int ready_mode = 0;
  int irq_seen = 0;
  int req_seen = 0;
  bit irq_prev = 1'b0;

  bit [7:0]     mem [bit [31:0]];
  logic [8:0]   exp_bytes[$];
  logic [63:0]  wr_act[$];
  logic [63:0]  wr_exp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txdesc_dma #(.BUF_BYTES(CAP)) u_txdesc_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] rdb(input bit [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic bit [31:0] rdw(input bit [31:0] a);
    return {rdb(a + 3), rdb(a + 2), rdb(a + 1), rdb(a)};
  endfunction

  task automatic put_word(input bit [31:0] a, input bit [31:0] d);
    mem[a] = d[7:0]; mem[a+1] = d[15:8]; mem[a+2] = d[23:16]; mem[a+3] = d[31:24];
  endtask

  // memory slave: one-cycle acknowledge, little-endian words
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem_byte ? {24'h0, rdb(mem_addr)} : rdw(mem_addr);
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && mem_ack && mem_we) begin
        mem[mem_addr]   = mem_wdata[7:0];
        mem[mem_addr+1] = mem_wdata[15:8];
        mem[mem_addr+2] = mem_wdata[23:16];
        mem[mem_addr+3] = mem_wdata[31:24];
      end
    end
    case (ready_mode)
      0:       tx_ready <= 1'b1;
      1:       tx_ready <= ((cyc % 3) != 0);
      default: tx_ready <= ((cyc % 5) == 0);
    endcase
  end

  // per-cycle reference comparison, taken between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        if (exp_bytes.size() == 0) begin
          chk(1'b0, "R5 unexpected byte", {23'h0, tx_last, tx_data}, 32'h0);
        end else begin
          logic [8:0] e;
          e = exp_bytes.pop_front();
          chk(tx_data == e[7:0], "R5 byte value/order", {24'h0, tx_data}, {24'h0, e[7:0]});
          chk(tx_last == e[8], "R6 last marker", {31'h0, tx_last}, {31'h0, e[8]});
        end
      end
      if (mem_req && mem_ack && mem_we) wr_act.push_back({mem_addr, mem_wdata});
      if (mem_req) req_seen++;
      if (irq) begin
        irq_seen++;
        if (irq_prev) chk(1'b0, "R10 irq wider than one cycle", 32'h1, 32'h0);
      end
      irq_prev = irq;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic make_desc(input bit [31:0] d, input bit [31:0] w0, input bit [31:0] lw,
                           input bit [31:0] link, input int n, input bit [7:0] seed);
    put_word(d, w0); put_word(d + 4, 32'h0); put_word(d + 8, lw); put_word(d + 12, link);
    for (int i = 0; i < n; i++) mem[{1'b0, w0[30:0]} + i] = seed + 8'(i * 7);
  endtask

  task automatic expect_frame(input bit [31:0] d, input bit [31:0] w0, input int n, input bit [7:0] seed);
    for (int i = 0; i < n; i++) exp_bytes.push_back({(i == n - 1), seed + 8'(i * 7)});
    wr_exp.push_back({d + 32'd8, 32'h0001_0000 | 32'(n)});
    wr_exp.push_back({d, {1'b0, w0[30:0]}});
  endtask

  task automatic wait_idle();
    logic [31:0] b;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 5000; k++) begin
      rreg(2'd2, b);
      if (b[0] == 1'b0) break;
    end
  endtask

  task automatic close_pass(input string tag);
    chk(exp_bytes.size() == 0, {tag, " bytes outstanding"}, exp_bytes.size(), 0);
    chk(wr_act.size() == wr_exp.size(), {tag, " write count"}, wr_act.size(), wr_exp.size());
    while (wr_act.size() > 0 && wr_exp.size() > 0) begin
      logic [63:0] a, e;
      a = wr_act.pop_front(); e = wr_exp.pop_front();
      chk(a[63:32] == e[63:32], {tag, " write address"}, a[63:32], e[63:32]);
      chk(a[31:0] == e[31:0], {tag, " write data"}, a[31:0], e[31:0]);
    end
    exp_bytes.delete(); wr_act.delete(); wr_exp.delete();
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rreg(2'd1, v); chk(v == 32'hFFFF_FFFF, "R1 pointer after reset", v, 32'hFFFF_FFFF);
    rreg(2'd0, v); chk(v == 32'h0, "R1 control after reset", v, 32'h0);
    chk(!irq && !tx_valid && !mem_req, "R1 outputs quiet", {irq, tx_valid, mem_req}, 32'h0);

    make_desc(32'h1000, 32'h8000_2000, 32'h0000_0005, 32'h1010, 5, 8'h10);
    make_desc(32'h1010, 32'h8000_2100, 32'h0000_0009, 32'h1020, 9, 8'h40);
    make_desc(32'h1020, 32'h0000_2200, 32'h0000_0004, 32'h1030, 4, 8'h70);
    make_desc(32'h1030, 32'h8000_2300, 32'hABCD_0041, 32'h1040, 0, 8'h00);
    make_desc(32'h1040, 32'h8000_2400, 32'h1234_0040, 32'h1050, 64, 8'h03);
    make_desc(32'h1050, 32'h8000_2600, 32'h0000_0000, 32'h1060, 0, 8'h00);

    wreg(2'd1, 32'h1000);
    rreg(2'd1, v); chk(v == 32'h1000, "R2 pointer write while idle", v, 32'h1000);

    // pass A: interrupt enabled, always ready
    expect_frame(32'h1000, 32'h8000_2000, 5, 8'h10);
    irq_seen = 0;
    wreg(2'd0, 32'h5);
    wait_idle();
    repeat (2) @(negedge clk);
    close_pass("R7/R8 pass A");
    rreg(2'd0, v); chk(v == 32'h5, "R2 control readback", v, 32'h5);
    rreg(2'd1, v); chk(v == 32'h1010, "R9 link loaded", v, 32'h1010);
    chk(irq_seen == 1, "R10 irq with enable", irq_seen, 1);
    chk(rdw(32'h1000) == 32'h0000_2000, "R8 ownership returned", rdw(32'h1000), 32'h2000);
    chk(rdw(32'h1008) == 32'h0001_0005, "R7 status in memory", rdw(32'h1008), 32'h0001_0005);

    // pass B: interrupt disabled, irregular ready
    ready_mode = 1;
    expect_frame(32'h1010, 32'h8000_2100, 9, 8'h40);
    irq_seen = 0;
    wreg(2'd0, 32'h1);
    wait_idle();
    repeat (2) @(negedge clk);
    close_pass("R5 pass B");
    chk(irq_seen == 0, "R10 no irq when disabled", irq_seen, 0);
    rreg(2'd1, v); chk(v == 32'h1020, "R9 second link", v, 32'h1020);

    // pass C: not owned
    ready_mode = 0;
    irq_seen = 0;
    wreg(2'd0, 32'h5);
    wait_idle();
    repeat (2) @(negedge clk);
    close_pass("R3 unowned");
    rreg(2'd1, v); chk(v == 32'h1020, "R3 pointer kept", v, 32'h1020);
    chk(irq_seen == 0, "R3 no irq", irq_seen, 0);

    // pass D: length over capacity with junk in upper half
    wreg(2'd1, 32'h1030);
    wreg(2'd0, 32'h5);
    wait_idle();
    repeat (2) @(negedge clk);
    close_pass("R4 oversized");
    rreg(2'd1, v); chk(v == 32'h1030, "R4 pointer kept", v, 32'h1030);
    chk(rdw(32'h1030) == 32'h8000_2300, "R4 descriptor untouched", rdw(32'h1030), 32'h8000_2300);

    // pass E: exactly capacity, slow consumer, writes while busy
    wreg(2'd1, 32'h1040);
    ready_mode = 2;
    expect_frame(32'h1040, 32'h8000_2400, 64, 8'h03);
    wreg(2'd0, 32'h1);
    repeat (20) @(negedge clk);
    rreg(2'd2, v); chk(v == 32'h1, "R11 busy reads set", v, 32'h1);
    wreg(2'd0, 32'h1);
    wreg(2'd1, 32'h9999_0000);
    wait_idle();
    repeat (2) @(negedge clk);
    close_pass("R4 full-size frame");
    rreg(2'd1, v); chk(v == 32'h1050, "R11 pointer write ignored while busy", v, 32'h1050);
    req_seen = 0;
    repeat (40) @(negedge clk);
    chk(req_seen == 0, "R11 no second pass from busy start", req_seen, 0);

    // pass F: zero length
    ready_mode = 0;
    expect_frame(32'h1050, 32'h8000_2600, 0, 8'h00);
    irq_seen = 0;
    wreg(2'd0, 32'h5);
    wait_idle();
    repeat (2) @(negedge clk);
    close_pass("R12 zero length");
    rreg(2'd1, v); chk(v == 32'h1060, "R12 link loaded", v, 32'h1060);
    chk(irq_seen == 1, "R12 irq after empty frame", irq_seen, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule